// File: doc/BRIEF.md
# Block Copy and Search Sequencer

This controller runs block memory operations on its own once it is started. Software-visible registers and instruction decode are not part of it. It owns a source pointer, a destination pointer, an element count and a one-byte key. On a start pulse it loads these values together with an 8-bit flag byte and a three-bit mode. The mode chooses copy or search, ascending or descending addresses, and one element or a run until termination. It then drives a byte-wide synchronous memory port, moves the pointers, counts down and updates the flags. It signals the end with a one-clock done pulse.

Each element takes a fixed number of clocks: 16 when the operation ends after it, 21 when another element follows. In copy mode it reads a byte at the source and writes it to the destination. In search mode it subtracts the byte at the source from the key, uses the result only for the flags, and never writes. A run of copies stops when the count reaches zero. A run of searches stops on the first matching byte or when the count reaches zero, whichever comes first.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset, busy, done, mem_rd and mem_wr are all 0.
- R2: A copy element reads the byte at the source pointer and writes it to the destination pointer. In ascending mode (op_dec=0) both pointers then move up by one, and the count goes down by one.
- R3: In descending mode (op_dec=1) each element moves the pointers down by one instead of up.
- R4: A search element reads the byte at the source pointer and performs no memory write. Only the source pointer moves, and the count goes down by one. The destination pointer is left unchanged.
- R5: With op_rep=1 in copy mode, elements repeat until the count is 0.
- R6: With op_rep=1 in search mode, elements stop after the first element whose byte equals the key, or when the count reaches 0.
- R7: Done rises 16 clock edges after the edge that accepts start for a single element. Each element that is followed by another adds 21 edges.
- R8: Flag bits are S=7, Z=6, H=4, PV=2, N=1, C=0. A copy element clears H and N and sets PV to 1 exactly when the count after the element is nonzero. It leaves S, Z, C, bit 5 and bit 3 as loaded.
- R9: A search element sets N=1 and PV as in R8. S is bit 7 of key minus byte, Z is 1 when they are equal, and H is 1 when the low nibble of the key is below the low nibble of the byte. C, bit 5 and bit 3 are preserved.
- R10: A start count of 0 wraps to 0xFFFF on the first element, so it stands for 65536 elements.
- R11: Done is high for exactly one clock. A start pulse while busy is ignored.
- R12: mem_rd and mem_wr are never high together, and neither is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| op_cmp | input | 1 | 1 = search, 0 = copy |
| op_dec | input | 1 | 1 = descending addresses |
| op_rep | input | 1 | 1 = repeat until termination |
| src_init | input | AW | Initial source pointer |
| dst_init | input | AW | Initial destination pointer |
| cnt_init | input | CW | Initial element count |
| key_init | input | DW | Search key |
| flag_init | input | 8 | Initial flag byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| src_ptr | output | AW | Current source pointer |
| dst_ptr | output | AW | Current destination pointer |
| count | output | CW | Current count |
| flags | output | 8 | Current flag byte |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Read request, data returns next clock |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data |

## Verification
A corrupted cycle counter shows up as done arriving on the wrong edge. That is visible within one element time, 16 or 21 clocks. A wrong captured byte appears at the next write as a bad destination byte, or for a search as wrong S, Z or H and a run that stops early or late. A faulty pointer or count step is visible in the registered outputs right after the element that caused it, so each scenario checks the final pointers, count, flags and the whole memory image against a model.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    typedef struct packed {
        logic cmp;
        logic dec;
        logic rep;
    } blk_mode_t;

    localparam int FLG_S  = 7;
    localparam int FLG_Z  = 6;
    localparam int FLG_H  = 4;
    localparam int FLG_PV = 2;
    localparam int FLG_N  = 1;
    localparam int FLG_C  = 0;

endpackage

// File: rtl/blkxfer_step.sv
module blkxfer_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic         dec,
    output logic [W-1:0] nxt
);
    always_comb begin
        nxt = dec ? (val - W'(1)) : (val + W'(1));
    end
endmodule

// File: rtl/blkxfer_flags.sv
module blkxfer_flags
    import blkxfer_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          is_cmp,
    input  logic [DW-1:0] key,
    input  logic [DW-1:0] data,
    input  logic          cnt_nz,
    input  logic [7:0]    f_in,
    output logic [7:0]    f_out
);
    localparam int HB = DW / 2;

    logic [DW-1:0] diff;
    logic          half_borrow;

    always_comb begin
        diff        = key - data;
        half_borrow = (key[HB-1:0] < data[HB-1:0]);
        f_out       = f_in;
        f_out[FLG_PV] = cnt_nz;
        if (is_cmp) begin
            f_out[FLG_S] = diff[DW-1];
            f_out[FLG_Z] = (diff == '0);
            f_out[FLG_H] = half_borrow;
            f_out[FLG_N] = 1'b1;
        end else begin
            f_out[FLG_H] = 1'b0;
            f_out[FLG_N] = 1'b0;
        end
    end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
    import blkxfer_pkg::*;
#(
    parameter int AW         = 16,
    parameter int CW         = 16,
    parameter int DW         = 8,
    parameter int SINGLE_CYC = 16,
    parameter int REPEAT_CYC = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_cmp,
    input  logic          op_dec,
    input  logic          op_rep,
    input  logic [AW-1:0] src_init,
    input  logic [AW-1:0] dst_init,
    input  logic [CW-1:0] cnt_init,
    input  logic [DW-1:0] key_init,
    input  logic [7:0]    flag_init,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] src_ptr,
    output logic [AW-1:0] dst_ptr,
    output logic [CW-1:0] count,
    output logic [7:0]    flags,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    localparam int CYW = $clog2(REPEAT_CYC);
    localparam logic [CYW-1:0] CYC_RD   = CYW'(0);
    localparam logic [CYW-1:0] CYC_CAP  = CYW'(1);
    localparam logic [CYW-1:0] CYC_WR   = CYW'(2);
    localparam logic [CYW-1:0] CYC_END  = CYW'(SINGLE_CYC - 1);
    localparam logic [CYW-1:0] CYC_LAST = CYW'(REPEAT_CYC - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CYW-1:0] cyc;
        blk_mode_t     mode;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [DW-1:0] key;
        logic [DW-1:0] data;
        logic [7:0]    flg;
    } state_t;

    state_t st_d, st_q;

    logic [AW-1:0] src_nx, dst_nx;
    logic [CW-1:0] cnt_nx;
    logic [7:0]    flg_nx;
    logic          cnt_nz, hit, go_on;
    logic [CYW-1:0] cyc_inc;

    blkxfer_step #(.W(AW)) u_src_step (.val(st_q.src), .dec(st_q.mode.dec), .nxt(src_nx));
    blkxfer_step #(.W(AW)) u_dst_step (.val(st_q.dst), .dec(st_q.mode.dec), .nxt(dst_nx));

    blkxfer_flags #(.DW(DW)) u_flags (
        .is_cmp (st_q.mode.cmp),
        .key    (st_q.key),
        .data   (st_q.data),
        .cnt_nz (cnt_nz),
        .f_in   (st_q.flg),
        .f_out  (flg_nx)
    );

    always_comb begin
        cnt_nx  = st_q.cnt - CW'(1);
        cnt_nz  = (cnt_nx != '0);
        hit     = (st_q.key == st_q.data);
        go_on   = st_q.mode.rep && cnt_nz && !(st_q.mode.cmp && hit);
        cyc_inc = (st_q.cyc == CYC_LAST) ? '0 : st_q.cyc + CYW'(1);

        st_d      = st_q;
        st_d.done = 1'b0;

        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.cyc  = '0;
                st_d.mode = '{cmp: op_cmp, dec: op_dec, rep: op_rep};
                st_d.src  = src_init;
                st_d.dst  = dst_init;
                st_d.cnt  = cnt_init;
                st_d.key  = key_init;
                st_d.flg  = flag_init;
            end
        end else begin
            if (st_q.cyc == CYC_CAP) begin
                st_d.data = mem_rdata;
            end
            if (st_q.cyc == CYC_END) begin
                st_d.src = src_nx;
                if (!st_q.mode.cmp) begin
                    st_d.dst = dst_nx;
                end
                st_d.cnt = cnt_nx;
                st_d.flg = flg_nx;
                if (go_on) begin
                    st_d.cyc = cyc_inc;
                end else begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                    st_d.cyc  = '0;
                end
            end else begin
                st_d.cyc = cyc_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign src_ptr   = st_q.src;
    assign dst_ptr   = st_q.dst;
    assign count     = st_q.cnt;
    assign flags     = st_q.flg;
    assign mem_rd    = st_q.busy && (st_q.cyc == CYC_RD);
    assign mem_wr    = st_q.busy && (st_q.cyc == CYC_WR) && !st_q.mode.cmp;
    assign mem_addr  = (st_q.cyc == CYC_WR) ? st_q.dst : st_q.src;
    assign mem_wdata = st_q.data;

endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          is_cmp,
    input logic [AW-1:0] src_ptr,
    input logic [AW-1:0] dst_ptr,
    input logic [CW-1:0] count
);
    AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr)); // R12
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_cmp) |-> !mem_wr); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R11
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && (count != $past(count))) |-> (count == $past(count) - CW'(1))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(src_ptr) && $stable(dst_ptr) && $stable(count))); // R11
endmodule

bind blkxfer_seq blkxfer_seq_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .is_cmp  (st_q.mode.cmp),
    .src_ptr (src_ptr),
    .dst_ptr (dst_ptr),
    .count   (count)
);

// File: tb/blkxfer_seq_tb.sv
`timescale 1ns/1ps
module blkxfer_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_cmp = 1'b0, op_dec = 1'b0, op_rep = 1'b0;
    logic [15:0] src_init = '0, dst_init = '0, cnt_init = '0;
    logic [7:0]  key_init = '0, flag_init = '0;
    logic        busy, done, mem_rd, mem_wr;
    logic [15:0] src_ptr, dst_ptr, count, mem_addr;
    logic [7:0]  flags, mem_wdata;
    logic [7:0]  mem_rdata = '0;

    logic [7:0] mem     [256];
    logic [7:0] ref_mem [256];

    int n_chk = 0;
    int n_err = 0;
    int n_wr  = 0;
    int n_clash = 0;

    always #2.5 clk = ~clk;

    blkxfer_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_cmp(op_cmp), .op_dec(op_dec), .op_rep(op_rep),
        .src_init(src_init), .dst_init(dst_init), .cnt_init(cnt_init),
        .key_init(key_init), .flag_init(flag_init),
        .busy(busy), .done(done), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
        .count(count), .flags(flags), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end

    always @(negedge clk) begin
        if (mem_wr) n_wr++;
        if ((mem_rd && mem_wr) || (!busy && (mem_rd || mem_wr))) n_clash++;
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
    endtask

    // Runs one operation against the model; poke_at > 0 pulses start mid-run.
    task automatic run_op(input string tag, input logic cmp, input logic dec, input logic rep,
                          input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                          input logic [7:0] a, input logic [7:0] f, input int poke_at);
        logic [15:0] ms = s, md = d, mc = c;
        logic [7:0]  mf = f, dat, df;
        int          n = 0, cyc = 0, exp_cyc, bad = 0;
        bit          stop = 0;
        while (!stop) begin
            dat = ref_mem[ms[7:0]];
            n++;
            if (!cmp) ref_mem[md[7:0]] = dat;
            mc = mc - 16'd1;
            ms = dec ? ms - 16'd1 : ms + 16'd1;
            if (!cmp) md = dec ? md - 16'd1 : md + 16'd1;
            mf[2] = (mc != 0);
            if (cmp) begin
                df = a - dat;
                mf[7] = df[7];
                mf[6] = (df == 0);
                mf[4] = (a[3:0] < dat[3:0]);
                mf[1] = 1'b1;
            end else begin
                mf[4] = 1'b0;
                mf[1] = 1'b0;
            end
            stop = !rep || (mc == 0) || (cmp && dat == a);
        end
        exp_cyc = 21 * (n - 1) + 16;

        n_wr = 0;
        n_clash = 0;
        @(negedge clk);
        op_cmp = cmp; op_dec = dec; op_rep = rep;
        src_init = s; dst_init = d; cnt_init = c; key_init = a; flag_init = f;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        src_init = 16'hDEAD; dst_init = 16'hBEEF; cnt_init = 16'h0003;
        while (cyc < 3000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (cyc == poke_at) start = 1'b1;
            else start = 1'b0;
            if (done) break;
        end
        start = 1'b0;
        check("R7", {tag, " done edge"}, 32'(cyc), 32'(exp_cyc));
        check(tag, "source pointer", 32'(src_ptr), 32'(ms));
        check(tag, "destination pointer", 32'(dst_ptr), 32'(md));
        check(tag, "count", 32'(count), 32'(mc));
        check(cmp ? "R9" : "R8", "flags", 32'(flags), 32'(mf));
        for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
        check(cmp ? "R4" : "R2", "memory mismatches", 32'(bad), 32'd0);
        check(cmp ? "R4" : "R2", "write count", 32'(n_wr), cmp ? 32'd0 : 32'(n));
        check("R12", "port clashes", 32'(n_clash), 32'd0);
        @(negedge clk);
        check("R11", "done width", 32'(done), 32'd0);
        check("R11", "busy after done", 32'(busy), 32'd0);
    endtask

    task automatic t_reset();
        check("R1", "busy", 32'(busy), 32'd0);
        check("R1", "done", 32'(done), 32'd0);
        check("R1", "mem_rd", 32'(mem_rd), 32'd0);
        check("R1", "mem_wr", 32'(mem_wr), 32'd0);
    endtask

    task automatic t_copy_up();
        run_op("R2", 1'b0, 1'b0, 1'b0, 16'h000A, 16'h0050, 16'h0005, 8'h00, 8'hFF, 0);
    endtask

    task automatic t_copy_down();
        run_op("R3", 1'b0, 1'b1, 1'b0, 16'h0030, 16'h0090, 16'h0001, 8'h00, 8'h00, 0);
    endtask

    task automatic t_search_single();
        run_op("R4", 1'b1, 1'b0, 1'b0, 16'h0012, 16'h0077, 16'h0009, 8'h05, 8'h01, 0);
    endtask

    task automatic t_copy_run();
        run_op("R5", 1'b0, 1'b0, 1'b1, 16'h0014, 16'h0064, 16'h0006, 8'h00, 8'hFF, 0);
        run_op("R5", 1'b0, 1'b1, 1'b1, 16'h00A0, 16'h00C8, 16'h0004, 8'h00, 8'h14, 0);
    endtask

    task automatic t_search_hit();
        run_op("R6", 1'b1, 1'b0, 1'b1, 16'h0020, 16'h0001, 16'h0010, ref_mem[8'h23], 8'h00, 0);
    endtask

    task automatic t_search_miss();
        run_op("R6", 1'b1, 1'b1, 1'b1, 16'h0040, 16'h0002, 16'h0004, 8'h00, 8'h29, 0);
    endtask

    task automatic t_zero_count();
        run_op("R10", 1'b0, 1'b0, 1'b0, 16'h0005, 16'h00F0, 16'h0000, 8'h00, 8'h00, 0);
    endtask

    task automatic t_busy_start();
        run_op("R11", 1'b0, 1'b0, 1'b1, 16'h0070, 16'h00B0, 16'h0003, 8'h00, 8'h00, 5);
    endtask

    initial begin
        #900_000;
        n_chk++;
        n_err++;
        $display("FAIL R7 watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        fill_mem();
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_copy_up();
        t_copy_down();
        t_search_single();
        t_copy_run();
        t_search_hit();
        t_search_miss();
        t_zero_count();
        t_busy_start();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule